// File: doc/BRIEF.md
# PCM Time-Slot Serial Interface

This block moves one byte-wide PCM sample per 8 kHz frame in each direction over a time-division serial bus clocked by a bit clock. A frame is a run of 8-bit slots, from one up to 64 of them. The block watches the frame sync and counts bit-clock periods to find the one slot that belongs to it. In that slot it sends the parallel transmit byte on one of two transmit lines and collects a byte from one of two receive lines.

Two framing modes are offered. In the immediate mode the frame sync edge marks the start of this block's own slot. In the counted mode the sync edge marks the start of the frame, and an internal slot counter locates the assigned slot number. Each transmit line is tri-state and has an active-low open-drain enable for a backplane line driver. The enable pulls low exactly while its line is carrying data.

The bit clock and frame sync are inputs sampled by the fabric clock `clk`, which must run well above the bit clock. Each output is a register or a tri-state buffer fed by a register.

Top module: `pcm_tsi`

## Requirements
- R1: After reset both transmit lines and both enables are released (high-impedance) and `rx_valid` is 0. Nothing becomes active until a frame sync edge has been seen.
- R2: A frame starts on the first bit-clock rising edge at which `fsync` is seen high after having been low. This works the same for a one-bit pulse and for a square wave.
- R3: With `frame_delayed`=0, the active slot is the 8-bit slot that begins at the frame start (slot 0). `slot_asg` is ignored.
- R4: With `frame_delayed`=1, slots are numbered from 0 at the frame start, and the active slot is the one whose number equals `slot_asg`.
- R5: During the active slot, the line selected by `port_sel` (0 selects `tx_line[0]`, 1 selects `tx_line[1]`) carries the byte MSB first. Each bit is updated after a bit-clock rising edge. The other line, and both lines outside the slot, are high-impedance.
- R6: `drv_en_n[p]` is driven low exactly while `tx_line[p]` is driven. At all other times it is high-impedance.
- R7: Receive bits are sampled on bit-clock falling edges, only from `rx_line[port_sel]` and only during the active slot, MSB first. After the eighth bit, `rx_byte` holds the byte and `rx_valid` pulses for one `clk` cycle. Data on the other line and in other slots has no effect.
- R8: An assigned slot that the frame never reaches never activates. Counting stops after slot 63, so a frame longer than 64 slots activates nothing past it.
- R9: Every frame sync edge restarts the slot count, so a frame of any length is followed by correct timing in the next frame.
- R10: `tx_byte` is captured at the first bit of the active slot. Later changes within the slot do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame sync, pulse or square wave |
| rx_line | input | NPORT | Serial receive lines |
| frame_delayed | input | 1 | 0: sync marks own slot; 1: sync marks frame start |
| slot_asg | input | SLOT_W | Assigned slot number (counted mode) |
| port_sel | input | PSEL_W | Selects the receive line and the transmit line |
| tx_byte | input | DATA_W | Byte to send in the active slot |
| tx_line | output | NPORT | Tri-state serial transmit lines |
| drv_en_n | output | NPORT | Open-drain active-low line-driver enables |
| rx_byte | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_byte` |

## Verification
Bit-clock inputs pass through one input register and then the position counters. A transmit bit and its enable therefore settle three `clk` cycles after the bit-clock rising edge is driven. The bench drives each bit-clock half period for four cycles and compares both lines and both enables on the third falling `clk` edge after each rise, against a behavioural model of slot position. A received byte is strobed two cycles after the last falling edge is seen. A monitor records every strobe, and after each frame the bench compares the strobe count and byte with what the model expects. Pull resistors in the bench turn the released state into known levels.

// File: rtl/pcm_tsi_pkg.sv
package pcm_tsi_pkg;
  typedef enum logic {
    FRM_IMMEDIATE = 1'b0,
    FRM_COUNTED   = 1'b1
  } frm_mode_e;
endpackage

// File: rtl/pcm_tsi_sense.sv
module pcm_tsi_sense #(
  parameter int NPORT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_in,
  input  logic             fs_in,
  input  logic [NPORT-1:0] rx_in,
  output logic             rise,
  output logic             fall,
  output logic             fs_s,
  output logic [NPORT-1:0] rx_s
);
  logic bclk_s, bclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_s <= 1'b0;
      bclk_d <= 1'b0;
      fs_s   <= 1'b0;
      rx_s   <= '0;
    end else begin
      bclk_s <= bclk_in;
      bclk_d <= bclk_s;
      fs_s   <= fs_in;
      rx_s   <= rx_in;
    end
  end

  assign rise = bclk_s & ~bclk_d;
  assign fall = ~bclk_s & bclk_d;
endmodule

// File: rtl/pcm_tsi_timer.sv
module pcm_tsi_timer
  import pcm_tsi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SLOT_W = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rise,
  input  logic                      fs_s,
  input  frm_mode_e                 mode,
  input  logic [SLOT_W-1:0]         slot_asg,
  output logic [$clog2(DATA_W)-1:0] bit_idx,
  output logic                      active,
  output logic                      upd
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DATA_W - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = '1;

  logic [SLOT_W-1:0] slot_q, slot_n;
  logic [BIT_W-1:0]  bit_n;
  logic              in_frame_q, in_frame_n;
  logic              fs_prev_q, fs_edge, act_n;

  assign fs_edge = fs_s & ~fs_prev_q;

  always_comb begin
    bit_n      = bit_idx;
    slot_n     = slot_q;
    in_frame_n = in_frame_q;
    if (fs_edge) begin
      bit_n      = '0;
      slot_n     = '0;
      in_frame_n = 1'b1;
    end else if (bit_idx == LAST_BIT) begin
      bit_n = '0;
      if (slot_q == LAST_SLOT) begin
        slot_n     = '0;
        in_frame_n = 1'b0;
      end else begin
        slot_n = slot_q + 1'b1;
      end
    end else begin
      bit_n = bit_idx + 1'b1;
    end
    if (mode == FRM_COUNTED) act_n = in_frame_n && (slot_n == slot_asg);
    else                     act_n = in_frame_n && (slot_n == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx    <= LAST_BIT;
      slot_q     <= '0;
      in_frame_q <= 1'b0;
      fs_prev_q  <= 1'b1;
      active     <= 1'b0;
      upd        <= 1'b0;
    end else begin
      upd <= rise;
      if (rise) begin
        bit_idx    <= bit_n;
        slot_q     <= slot_n;
        in_frame_q <= in_frame_n;
        fs_prev_q  <= fs_s;
        active     <= act_n;
      end
    end
  end
endmodule

// File: rtl/pcm_tsi_tx.sv
module pcm_tsi_tx #(
  parameter int DATA_W = 8,
  parameter int NPORT  = 2,
  parameter int PSEL_W = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      upd,
  input  logic                      active,
  input  logic [$clog2(DATA_W)-1:0] bit_idx,
  input  logic [DATA_W-1:0]         tx_byte,
  input  logic [PSEL_W-1:0]         port_sel,
  output logic [NPORT-1:0]          oe,
  output logic                      dout
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      oe   <= '0;
      dout <= 1'b0;
    end else if (upd) begin
      if (active) begin
        oe <= NPORT'(1) << port_sel;
        if (bit_idx == '0) begin
          dout <= tx_byte[DATA_W-1];
          sh_q <= tx_byte << 1;
        end else begin
          dout <= sh_q[DATA_W-1];
          sh_q <= sh_q << 1;
        end
      end else begin
        oe <= '0;
      end
    end
  end
endmodule

// File: rtl/pcm_tsi_rx.sv
module pcm_tsi_rx #(
  parameter int DATA_W = 8,
  parameter int NPORT  = 2,
  parameter int PSEL_W = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fall,
  input  logic                      active,
  input  logic [$clog2(DATA_W)-1:0] bit_idx,
  input  logic [NPORT-1:0]          rx_s,
  input  logic [PSEL_W-1:0]         port_sel,
  output logic [DATA_W-1:0]         rx_byte,
  output logic                      rx_valid
);
  localparam logic [$clog2(DATA_W)-1:0] LAST_BIT = $clog2(DATA_W)'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_n;

  assign sh_n = {sh_q[DATA_W-2:0], rx_s[port_sel]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (fall && active) begin
        sh_q <= sh_n;
        if (bit_idx == LAST_BIT) begin
          rx_byte  <= sh_n;
          rx_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_tsi.sv
module pcm_tsi
  import pcm_tsi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SLOT_W = 6,
  parameter int NPORT  = 2,
  parameter int PSEL_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk,
  input  logic              fsync,
  input  logic [NPORT-1:0]  rx_line,
  input  logic              frame_delayed,
  input  logic [SLOT_W-1:0] slot_asg,
  input  logic [PSEL_W-1:0] port_sel,
  input  logic [DATA_W-1:0] tx_byte,
  output logic [NPORT-1:0]  tx_line,
  output logic [NPORT-1:0]  drv_en_n,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid
);
  localparam int BIT_W = $clog2(DATA_W);

  logic                rise, fall, fs_s, active, upd, dout;
  logic [NPORT-1:0]    rx_s, oe;
  logic [BIT_W-1:0]    bit_idx;
  frm_mode_e           mode;

  assign mode = frame_delayed ? FRM_COUNTED : FRM_IMMEDIATE;

  pcm_tsi_sense #(.NPORT(NPORT)) u_sense (
    .clk(clk), .rst(rst), .bclk_in(bclk), .fs_in(fsync), .rx_in(rx_line),
    .rise(rise), .fall(fall), .fs_s(fs_s), .rx_s(rx_s)
  );

  pcm_tsi_timer #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_timer (
    .clk(clk), .rst(rst), .rise(rise), .fs_s(fs_s), .mode(mode),
    .slot_asg(slot_asg), .bit_idx(bit_idx), .active(active), .upd(upd)
  );

  pcm_tsi_tx #(.DATA_W(DATA_W), .NPORT(NPORT), .PSEL_W(PSEL_W)) u_tx (
    .clk(clk), .rst(rst), .upd(upd), .active(active), .bit_idx(bit_idx),
    .tx_byte(tx_byte), .port_sel(port_sel), .oe(oe), .dout(dout)
  );

  pcm_tsi_rx #(.DATA_W(DATA_W), .NPORT(NPORT), .PSEL_W(PSEL_W)) u_rx (
    .clk(clk), .rst(rst), .fall(fall), .active(active), .bit_idx(bit_idx),
    .rx_s(rx_s), .port_sel(port_sel), .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_pad
    assign tx_line[g]  = oe[g] ? dout : 1'bz;
    assign drv_en_n[g] = oe[g] ? 1'b0 : 1'bz;
  end
endmodule

// File: rtl/pcm_tsi_chk.sv
module pcm_tsi_chk #(
  parameter int DATA_W = 8,
  parameter int NPORT  = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      rise,
  input logic                      fall,
  input logic                      upd,
  input logic                      active,
  input logic [$clog2(DATA_W)-1:0] bit_idx,
  input logic [NPORT-1:0]          oe,
  input logic                      dout,
  input logic                      rx_valid
);
  // R5: at most one transmit line driven at a time
  a_r5_single_port: assert property (@(posedge clk) disable iff (rst)
    $onehot0(oe));

  // R5: a line is only driven once the slot timer has flagged the slot
  a_r5_drive_in_slot: assert property (@(posedge clk) disable iff (rst)
    $rose(|oe) |-> $past(active));

  // R2: slot position only advances on a bit-clock rising edge
  a_r2_step_on_rise: assert property (@(posedge clk) disable iff (rst)
    !$stable(bit_idx) |-> $past(rise));

  // R10: the outgoing bit only changes on a position update
  a_r10_bit_held: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> $past(upd));

  // R7: valid is a single-cycle strobe that follows a falling edge
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  a_r7_valid_after_fall: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(fall));
endmodule

bind pcm_tsi pcm_tsi_chk #(.DATA_W(DATA_W), .NPORT(NPORT)) u_chk (
  .clk(clk), .rst(rst), .rise(rise), .fall(fall), .upd(upd),
  .active(active), .bit_idx(bit_idx), .oe(oe), .dout(dout),
  .rx_valid(rx_valid)
);

// File: tb/pcm_tsi_test.sv
`timescale 1ns/1ps
module pcm_tsi_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bclk = 1'b0;
  logic       fsync = 1'b0;
  logic [1:0] rx_line = 2'b00;
  logic       frame_delayed = 1'b0;
  logic [5:0] slot_asg = '0;
  logic [0:0] port_sel = '0;
  logic [7:0] tx_byte = '0;
  wire  [1:0] tx_w;
  wire  [1:0] en_w;
  logic [7:0] rx_byte;
  logic       rx_valid;

  int errors = 0;
  int checks = 0;
  int vcnt = 0;
  logic [7:0] vbyte = '0;

  always #4 clk = ~clk;

  // released lines read as 0 (data) and 1 (enable)
  pulldown (tx_w[0]);
  pulldown (tx_w[1]);
  pullup   (en_w[0]);
  pullup   (en_w[1]);

  pcm_tsi uut (
    .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync), .rx_line(rx_line),
    .frame_delayed(frame_delayed), .slot_asg(slot_asg), .port_sel(port_sel),
    .tx_byte(tx_byte), .tx_line(tx_w), .drv_en_n(en_w),
    .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  always @(negedge clk) if (!rst && rx_valid) begin
    vcnt  = vcnt + 1;
    vbyte = rx_byte;
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One frame: model decides which slot is active; compare every bit period.
  task automatic run_frame(input string req, input int nslots, input bit delayed,
                           input int asg, input int port, input logic [7:0] txb,
                           input logic [7:0] rxb, input bit square);
    int act_slot = delayed ? asg : 0;
    bit live = (act_slot < nslots) && (act_slot < 64);
    frame_delayed = delayed;
    slot_asg = 6'(asg);
    port_sel = 1'(port);
    tx_byte = txb;
    vcnt = 0;
    for (int s = 0; s < nslots; s++) begin
      for (int b = 0; b < 8; b++) begin
        bit mine = live && (s == act_slot);
        @(negedge clk);
        bclk = 1'b1;
        fsync = square ? ((s * 8 + b) < (nslots * 4)) : (s == 0 && b == 0);
        if (mine && b == 2) tx_byte = ~txb;       // R10: late change ignored
        rx_line = 2'($urandom);
        if (mine) rx_line[port] = rxb[7-b];
        repeat (3) @(negedge clk);
        for (int p = 0; p < 2; p++) begin
          bit drv = mine && (p == port);
          check(req, int'(tx_w[p]), drv ? int'(txb[7-b]) : 0, $sformatf("tx_line[%0d] s%0d b%0d", p, s, b));
          check(req, int'(en_w[p]), drv ? 0 : 1, $sformatf("drv_en_n[%0d] s%0d b%0d", p, s, b));
        end
        @(negedge clk);
        bclk = 1'b0;
        repeat (4) @(negedge clk);
      end
    end
    fsync = 1'b0;
    repeat (4) @(negedge clk);
    check(req, vcnt, live ? 1 : 0, "rx_valid count");
    if (live) check(req, int'(vbyte), int'(rxb), "rx_byte");
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: released state after reset
    check("R1", int'(tx_w), 0, "tx_line after reset");
    check("R1", int'(en_w), 3, "drv_en_n after reset");
    check("R1", int'(rx_valid), 0, "rx_valid after reset");
    // R1: bit clock without frame sync activates nothing (nslots run with no sync)
    for (int b = 0; b < 16; b++) begin
      @(negedge clk); bclk = 1'b1; repeat (3) @(negedge clk);
      check("R1", int'(en_w), 3, "enable before first sync");
      @(negedge clk); bclk = 1'b0; repeat (4) @(negedge clk);
    end
    // R3: immediate mode, slot_asg ignored, pulse sync, port 0
    run_frame("R3", 4, 1'b0, 3, 0, 8'hA5, 8'h3C, 1'b0);
    // R3/R5: immediate mode, port 1, square-wave sync (R2)
    run_frame("R2", 4, 1'b0, 0, 1, 8'h96, 8'hE1, 1'b1);
    // R4: counted mode, slot 2 of 5, port 0
    run_frame("R4", 5, 1'b1, 2, 0, 8'h5A, 8'h81, 1'b0);
    // R6/R7: counted mode, slot 3, port 1, square sync
    run_frame("R7", 6, 1'b1, 3, 1, 8'hF0, 8'h0F, 1'b1);
    // R8: assigned slot beyond the frame
    run_frame("R8", 3, 1'b1, 4, 0, 8'hFF, 8'h55, 1'b0);
    // R9: short irregular frame then longer one, same assignment
    run_frame("R9", 2, 1'b1, 1, 0, 8'h12, 8'h34, 1'b0);
    run_frame("R9", 7, 1'b1, 6, 1, 8'hC3, 8'h7E, 1'b0);
    // R6: last slot of a 64-slot frame
    run_frame("R6", 64, 1'b1, 63, 0, 8'h69, 8'hB4, 1'b1);
    // R8: frame longer than 64 slots, slot 1 must fire once only
    run_frame("R8", 66, 1'b1, 1, 1, 8'h3A, 8'hC5, 1'b0);
    // R10/R5: slot 0 in counted mode, all-ones then all-zeros pattern
    run_frame("R10", 2, 1'b1, 0, 0, 8'hFF, 8'h00, 1'b0);
    run_frame("R5", 2, 1'b1, 1, 1, 8'h01, 8'h80, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule